// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is one general-purpose I/O port whose pins are each configured as an input or an output, with per-pin interrupt detection behind a small register interface. Software programs the output value, the drive enables and the interrupt setup through a write strobe, an address and a data word. Register contents come back combinationally on a read data bus. Each pin's incoming value passes through a two-stage synchronizer. The synchronized value is then compared with the previous one to find edges.

Each pin has a sense-mode bit and a polarity bit. Together they select one of four conditions: rising edge, falling edge, high level or low level. A pin that meets its condition sets a sticky pending bit, but only if the pin is routed to interrupt detection. A second mask, the enable register, decides which pending bits drive the single port interrupt line. Every writable register accepts a full load, an OR-in (set) and an AND-out (clear) at fixed alias offsets. Software can therefore change single bits without a read-modify-write sequence. Because a polarity change applies to the very next detected event, software can get both-edge sensing by flipping the polarity after each interrupt.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, pinOe and pinOut are zero and irqOut is low.
- R2: Address bits [7:4] select the register: 0 output data, 1 output enable, 2 interrupt routing, 3 interrupt enable, 4 sense mode, 5 polarity, 6 input data, 7 pending status. Address bits [3:0] select the operation: 0x0 loads the word, 0x4 ORs it in, and 0x8 clears every bit that is 1 in the word. The writable registers take effect on the clock edge of the write.
- R3: pinOut always equals the output data register and pinOe equals the output enable register (1 = pin driven, 0 = pin is an input).
- R4: The input data register shows the pin value two clock edges after it is applied to pinIn. Writes to slot 6 change nothing.
- R5: A sense-mode bit of 1 selects level sensing and 0 selects edge sensing. A polarity bit of 1 selects high level or rising edge, and 0 selects low level or falling edge.
- R6: Pending bits are sticky and drop only through the clear alias (address 0x78). Writing all ones there clears every bit that has no active event. Loads (0x70) and set-alias writes (0x74) to the status register have no effect.
- R7: A pin whose routing bit is 0 never sets its pending bit.
- R8: irqOut is high in the same cycle in which any pending bit whose enable bit is 1 is set. Otherwise it is low.
- R9: A polarity change applies to the next event, so flipping the polarity after each event catches both edges.
- R10: In level mode, clearing a pending bit while the active level is still present leaves it set.
- R11: If an event and a clear of the same pending bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Register slot [7:4] and operation [3:0] |
| busWdata | input | 32 | Write data, one bit per pin |
| busRdata | output | 32 | Contents of the slot addressed by busAddr |
| pinIn | input | 32 | Asynchronous pin input values |
| pinOut | output | 32 | Output data toward the pads |
| pinOe | output | 32 | Per-pin drive enable |
| irqOut | output | 1 | Combined port interrupt |

## Verification
The vector table sets four pins to the four sense combinations at once. It then applies start/end pin patterns: rising, falling, steady-low, steady-high and mixed swaps. A level pin that was active only in the start pattern tells sticky status apart from a live level. Edge pins that see the opposite transition tell the polarity decode apart from simple change detection. Directed runs separate event-versus-clear priority, the level re-set after a clear, both-edge sensing by flipping the polarity, and the two masks, each of which alone blocks either status or the interrupt line.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  // register slots, selected by the upper address nibble
  localparam int SLOT_DOUT   = 0;
  localparam int SLOT_OE     = 1;
  localparam int SLOT_ROUTE  = 2;
  localparam int SLOT_IEN    = 3;
  localparam int SLOT_LEV    = 4;
  localparam int SLOT_POL    = 5;
  localparam int SLOT_DIN    = 6;
  localparam int SLOT_STATUS = 7;
  localparam int RW_REGS     = 6;   // slots 0..5 are plain writable registers

  // operation codes, lower address nibble
  localparam logic [3:0] OP_LOAD = 4'h0;
  localparam logic [3:0] OP_SET  = 4'h4;
  localparam logic [3:0] OP_CLR  = 4'h8;

  typedef struct packed {
    logic [RW_REGS-1:0] regSel;     // one-hot target among writable registers
    logic               doLoad;
    logic               doSet;
    logic               doClr;
    logic               statusClr;  // clear alias of the pending register
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  doutQ,
  input  logic [WIDTH-1:0]  oeQ,
  input  logic [WIDTH-1:0]  routeQ,
  input  logic [WIDTH-1:0]  ienQ,
  input  logic [WIDTH-1:0]  levQ,
  input  logic [WIDTH-1:0]  polQ,
  input  logic [WIDTH-1:0]  dinQ,
  input  logic [WIDTH-1:0]  statusQ,
  output ctrlStrobe_t       strobe,
  output logic [WIDTH-1:0]  busRdata
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slotIdx;
  logic [3:0]        opCode;

  assign slotIdx = busAddr[ADDR_W-1:4];
  assign opCode  = busAddr[3:0];

  always_comb begin
    strobe = '0;
    if (busWr) begin
      strobe.doLoad = (opCode == OP_LOAD);
      strobe.doSet  = (opCode == OP_SET);
      strobe.doClr  = (opCode == OP_CLR);
      for (int i = 0; i < RW_REGS; i++) begin
        strobe.regSel[i] = (slotIdx == SLOT_W'(i));
      end
      strobe.statusClr = (slotIdx == SLOT_W'(SLOT_STATUS)) && (opCode == OP_CLR);
    end
  end

  always_comb begin
    unique case (slotIdx)
      SLOT_W'(SLOT_DOUT):   busRdata = doutQ;
      SLOT_W'(SLOT_OE):     busRdata = oeQ;
      SLOT_W'(SLOT_ROUTE):  busRdata = routeQ;
      SLOT_W'(SLOT_IEN):    busRdata = ienQ;
      SLOT_W'(SLOT_LEV):    busRdata = levQ;
      SLOT_W'(SLOT_POL):    busRdata = polQ;
      SLOT_W'(SLOT_DIN):    busRdata = dinQ;
      SLOT_W'(SLOT_STATUS): busRdata = statusQ;
      default:              busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense #(
  parameter int WIDTH      = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] levelSel,
  input  logic [WIDTH-1:0] polarity,
  output logic [WIDTH-1:0] syncIn,
  output logic [WIDTH-1:0] eventVec
);
  logic [WIDTH-1:0] syncStage [SYNC_DEPTH];
  logic [WIDTH-1:0] prevIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_DEPTH; s++) syncStage[s] <= '0;
      prevIn <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_DEPTH; s++) syncStage[s] <= syncStage[s-1];
      prevIn <= syncStage[SYNC_DEPTH-1];
    end
  end

  assign syncIn = syncStage[SYNC_DEPTH-1];

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
    logic levelHit;
    logic edgeHit;
    // active level matches polarity; edge ends at the polarity value
    assign levelHit = ~(syncIn[gi] ^ polarity[gi]);
    assign edgeHit  = (syncIn[gi] ^ prevIn[gi]) & levelHit;
    assign eventVec[gi] = levelSel[gi] ? levelHit : edgeHit;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
`timescale 1ns/1ps
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] doutQ,
  output logic [WIDTH-1:0] oeQ,
  output logic [WIDTH-1:0] routeQ,
  output logic [WIDTH-1:0] ienQ,
  output logic [WIDTH-1:0] levQ,
  output logic [WIDTH-1:0] polQ,
  output logic [WIDTH-1:0] dinQ,
  output logic [WIDTH-1:0] statusQ,
  output logic             irqOut
);
  logic [WIDTH-1:0] rwQ [RW_REGS];
  logic [WIDTH-1:0] eventVec;
  logic [WIDTH-1:0] clrMask;

  for (genvar gr = 0; gr < RW_REGS; gr++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rwQ[gr] <= '0;
      end else if (strobe.regSel[gr]) begin
        if (strobe.doLoad)     rwQ[gr] <= busWdata;
        else if (strobe.doSet) rwQ[gr] <= rwQ[gr] | busWdata;
        else if (strobe.doClr) rwQ[gr] <= rwQ[gr] & ~busWdata;
      end
    end
  end

  assign doutQ  = rwQ[SLOT_DOUT];
  assign oeQ    = rwQ[SLOT_OE];
  assign routeQ = rwQ[SLOT_ROUTE];
  assign ienQ   = rwQ[SLOT_IEN];
  assign levQ   = rwQ[SLOT_LEV];
  assign polQ   = rwQ[SLOT_POL];

  gpio_irq_sense #(.WIDTH(WIDTH), .SYNC_DEPTH(2)) sense_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .levelSel (levQ),
    .polarity (polQ),
    .syncIn   (dinQ),
    .eventVec (eventVec)
  );

  assign clrMask = strobe.statusClr ? busWdata : '0;

  // new events are OR-ed after the clear, so an event wins a collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= '0;
    else        statusQ <= (statusQ & ~clrMask) | (eventVec & routeQ);
  end

  assign irqOut = |(statusQ & ienQ);
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic              irqOut
);
  ctrlStrobe_t      strobe;
  logic [WIDTH-1:0] doutQ, oeQ, routeQ, ienQ, levQ, polQ, dinQ, statusQ;

  gpio_irq_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) ctrl_i (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .doutQ    (doutQ),
    .oeQ      (oeQ),
    .routeQ   (routeQ),
    .ienQ     (ienQ),
    .levQ     (levQ),
    .polQ     (polQ),
    .dinQ     (dinQ),
    .statusQ  (statusQ),
    .strobe   (strobe),
    .busRdata (busRdata)
  );

  gpio_irq_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .doutQ    (doutQ),
    .oeQ      (oeQ),
    .routeQ   (routeQ),
    .ienQ     (ienQ),
    .levQ     (levQ),
    .polQ     (polQ),
    .dinQ     (dinQ),
    .statusQ  (statusQ),
    .irqOut   (irqOut)
  );

  assign pinOut = doutQ;
  assign pinOe  = oeQ;
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  statusQ,
  input logic [WIDTH-1:0]  routeQ
);
  localparam logic [ADDR_W-1:0] DOUT_LOAD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OE_CLR     = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] STAT_CLR   = ADDR_W'(8'h78);

  // R6: pending bits only fall after a clear-alias write
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && busAddr == STAT_CLR) |=> (($past(statusQ) & ~statusQ) == '0));

  // R7: an unrouted pin never raises its pending bit
  p_route_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusQ & ~$past(statusQ) & ~$past(routeQ)) == '0));

  // R2/R3: a load of the output data register appears on pinOut next cycle
  p_dout_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == DOUT_LOAD) |=> (pinOut == $past(busWdata)));

  // R2/R3: a clear-alias write to output enable drops those drive enables
  p_oe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == OE_CLR) |=> ((pinOe & $past(busWdata)) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .statusQ  (statusQ),
  .routeQ   (routeQ)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h10, A_ROUTE = 8'h20, A_IEN = 8'h30;
  localparam logic [7:0] A_LEV = 8'h40, A_POL = 8'h50, A_DIN = 8'h60, A_STAT = 8'h70;
  localparam logic [7:0] O_SET = 8'h04, O_CLR = 8'h08;

  // {start pins, end pins, expected status} on pins 3..0
  // pin0 falling edge, pin1 rising edge, pin2 low level, pin3 high level
  localparam int NVEC = 6;
  localparam logic [11:0] VECS [NVEC] = '{12'h0FE, 12'hF0D, 12'h550, 12'hAAC, 12'h3CD, 12'hC3E};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk);
    #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1;
    data = busRdata;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    tick(3);
    // R1: reset state
    for (int s = 0; s < 8; s++) begin
      rd(8'(s * 16), v);
      check("R1 register zero", v, 32'h0);
    end
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 irqOut", {31'h0, irqOut}, 32'h0);
    rst_n = 1'b1;
    tick(1);

    // vector table: four sense combinations on pins 3..0
    wr(A_LEV, 32'hC);
    wr(A_POL, 32'hA);
    wr(A_ROUTE, 32'hFFFF_FFFF);
    for (int k = 0; k < NVEC; k++) begin
      pinIn = {28'h0, VECS[k][11:8]};
      tick(4);
      wr(A_STAT | O_CLR, 32'hFFFF_FFFF);
      pinIn = {28'h0, VECS[k][7:4]};
      tick(4);
      rd(A_STAT, v);
      check("R5 sense table", v, {28'h0, VECS[k][3:0]});
    end

    // R6: clear all with inactive pins, and status load/set ignored
    pinIn = 32'h5;          // pin2 high (inactive low level), pin3 low (inactive)
    tick(4);
    wr(A_STAT | O_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, v);
    check("R6 clear all", v, 32'h0);
    wr(A_STAT, 32'h00F0_0000);
    wr(A_STAT | O_SET, 32'h0F00_0000);
    rd(A_STAT, v);
    check("R6 status load/set ignored", v, 32'h0);

    // R2 / R3: load, set, clear aliases
    wr(A_DOUT, 32'h1234_5678);
    check("R3 pinOut load", pinOut, 32'h1234_5678);
    wr(A_DOUT | O_SET, 32'h0000_000F);
    check("R2 set alias", pinOut, 32'h1234_567F);
    wr(A_DOUT | O_CLR, 32'h1200_0003);
    check("R2 clear alias", pinOut, 32'h0034_567C);
    wr(A_OE | O_SET, 32'hFF00_0000);
    check("R3 pinOe", pinOe, 32'hFF00_0000);
    wr(A_IEN, 32'hA5A5_0000);
    rd(A_IEN, v);
    check("R2 enable readback", v, 32'hA5A5_0000);
    wr(A_IEN, 32'h0);

    // R4: two-stage synchronizer latency and read-only input register
    pinIn = 32'hDEAD_BEE5;
    tick(1);
    rd(A_DIN, v);
    check("R4 din after one edge", v, 32'h0000_0005);
    tick(1);
    rd(A_DIN, v);
    check("R4 din after two edges", v, 32'hDEAD_BEE5);
    wr(A_DIN, 32'h0);
    rd(A_DIN, v);
    check("R4 din write ignored", v, 32'hDEAD_BEE5);
    pinIn = 32'h5;
    tick(4);
    wr(A_STAT | O_CLR, 32'hFFFF_FFFF);

    // R7: unrouted pin1 rising edge leaves no status
    wr(A_ROUTE | O_CLR, 32'h2);
    pinIn = 32'h7;
    tick(4);
    rd(A_STAT, v);
    check("R7 unrouted pin", v, 32'h0);
    pinIn = 32'h5;
    wr(A_ROUTE | O_SET, 32'h2);
    tick(4);

    // R11: rising edge on pin1 collides with its clear
    pinIn = 32'h7;
    tick(2);
    wr(A_STAT | O_CLR, 32'h2);
    rd(A_STAT, v);
    check("R11 event beats clear", v, 32'h2);

    // R8: enable mask gates the interrupt line
    check("R8 irq masked", {31'h0, irqOut}, 32'h0);
    wr(A_IEN, 32'h1);
    check("R8 other pin enabled", {31'h0, irqOut}, 32'h0);
    wr(A_IEN | O_SET, 32'h2);
    check("R8 irq raised", {31'h0, irqOut}, 32'h1);
    wr(A_STAT | O_CLR, 32'h2);
    check("R8 irq dropped", {31'h0, irqOut}, 32'h0);

    // R10: level-low pin2 stays pending while low
    pinIn = 32'h3;
    tick(4);
    wr(A_STAT | O_CLR, 32'h4);
    rd(A_STAT, v);
    check("R10 level re-set", v & 32'h4, 32'h4);
    pinIn = 32'h7;
    tick(4);
    wr(A_STAT | O_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, v);
    check("R10 level gone", v, 32'h0);

    // R9: both-edge sensing on pin5 by flipping the polarity
    wr(A_POL | O_SET, 32'h20);
    pinIn = 32'h27;
    tick(4);
    rd(A_STAT, v);
    check("R9 rising caught", v, 32'h20);
    wr(A_STAT | O_CLR, 32'h20);
    wr(A_POL | O_CLR, 32'h20);
    tick(2);
    rd(A_STAT, v);
    check("R9 flip makes no event", v, 32'h0);
    pinIn = 32'h07;
    tick(4);
    rd(A_STAT, v);
    check("R9 falling caught", v, 32'h20);

    finishRun();
  end
endmodule